// File: doc/BRIEF.md
# Reservation Monitor for Locked-Load / Conditional-Store Atomics

This block holds the reservation that one processor uses for a lock-free read-modify-write. Software issues a locked load, changes the value in a register, and then issues a conditional store. The conditional store writes memory only if the reservation is still intact. The block answers in the same cycle with a pass/fail bit, and software tests that bit and repeats the whole sequence on failure. Addresses are 64-bit byte addresses and data words are 64 bits wide. One reservation covers an aligned 8-byte granule, which is address bits [63:3].

The reservation lives in a two-state machine. In state `RSV_EMPTY` no lock is held. In state `RSV_HELD` a granule tag is stored. Three kinds of event destroy the reservation: a snoop write from another agent that hits the held granule, an interrupt, and an exception. The transitions are:
- **ARM**: `RSV_EMPTY` → `RSV_HELD`, taken on a locked load with no kill event in that cycle.
- **REARM**: `RSV_HELD` → `RSV_HELD`, taken on a locked load with no kill event. It replaces the stored tag.
- **DROP**: `RSV_HELD` → `RSV_EMPTY`, taken on any conditional store or any kill event.
- **STAY**: every other case leaves the state unchanged.

The block never stalls other agents' writes. It only observes them.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held, so a conditional store issued right after reset fails and `mem_we` stays 0.
- R2: A locked load (`req_op`=2'b01) records address bits [63:3]. A later conditional store (`req_op`=2'b10) to any byte of that granule succeeds in the same cycle. In that cycle `sc_done`=1, `sc_success`=1, `mem_we`=1, `mem_waddr` equals `req_addr` and `mem_wdata` equals `req_wdata`.
- R3: A conditional store issued while no reservation is held fails in the same cycle, with `sc_done`=1, `sc_success`=0 and `mem_we`=0.
- R4: A conditional store whose bits [63:3] differ from the reserved granule fails and does not write.
- R5: Every conditional store ends the reservation, whether it succeeds or fails. A second conditional store to the same granule therefore fails.
- R6: A snoop write that hits the reserved granule ends the reservation. A snoop write to another granule leaves the reservation intact.
- R7: An interrupt pulse between the locked load and the conditional store ends the reservation.
- R8: An exception pulse between the locked load and the conditional store ends the reservation.
- R9: A new locked load replaces the held reservation. After it, a store to the old granule fails and a store to the new granule succeeds.
- R10: When a snoop write and a conditional store hit the reserved granule in the same cycle, the snoop wins, the store fails and no write is issued.
- R11: A locked load in the same cycle as an interrupt, an exception or a hitting snoop leaves no reservation.
- R12: `sc_done` is 1 only for conditional-store requests. Op codes 2'b00 and 2'b11 produce no response, do not write, and leave the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 2 | Request code: 00 idle, 01 locked load, 10 conditional store, 11 ignored |
| req_addr | input | 64 | Byte address of the request |
| req_wdata | input | 64 | Data for a conditional store |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | 64 | Byte address of that write |
| irq_event | input | 1 | Interrupt taken this cycle |
| exc_event | input | 1 | Exception taken this cycle |
| mem_we | output | 1 | Memory write enable for a successful conditional store |
| mem_waddr | output | 64 | Write address, 0 when no write |
| mem_wdata | output | 64 | Write data, 0 when no write |
| sc_done | output | 1 | A conditional store is answered this cycle |
| sc_success | output | 1 | The conditional store passed |

## Verification
The bench first runs the plain load-then-store pair, using a store at a different byte offset of the same granule. This separates granule matching from full-address matching. It then places each kind of interference between the two requests: an interrupt, an exception, a snoop to the held granule and a snoop to a neighbouring granule. This separates the events that must kill the reservation from those that must leave it alone. It also drives the same-cycle collisions (snoop with store, kill with load), back-to-back stores, reloads to a new granule and the ignored op codes. These cases pin down priority and show that the reservation is dropped after every store.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Request codes on req_op
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LL   = 2'b01,
        OP_SC   = 2'b10,
        OP_RSVD = 2'b11
    } llsc_op_e;

    // Reservation state
    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/llsc_tag_cmp.sv
// Granule tag comparator, qualified by a valid input.
module llsc_tag_cmp #(
    parameter int TAG_W = 61
) (
    input  logic [TAG_W-1:0] probe_tag,
    input  logic [TAG_W-1:0] held_tag,
    input  logic             qual,
    output logic             hit
);
    always_comb begin
        hit = qual && (probe_tag == held_tag);
    end
endmodule

// File: rtl/llsc_kill_merge.sv
// Merges all reservation-destroying sources into one kill strobe.
module llsc_kill_merge #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src,
    output logic             kill
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src[i];
    end
    assign kill = chain[N_SRC];
endmodule

// File: rtl/llsc_rsv_fsm.sv
// Reservation state machine and stored granule tag.
module llsc_rsv_fsm
    import llsc_pkg::*;
#(
    parameter int TAG_W = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic             store_req,
    input  logic             kill,
    input  logic [TAG_W-1:0] load_tag,
    output logic             lock_valid,
    output logic [TAG_W-1:0] rsv_tag
);
    rsv_state_e       state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    // Next state
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (load_req && !kill) begin          // ARM
                    state_d = RSV_HELD;
                    tag_d   = load_tag;
                end
            end
            RSV_HELD: begin
                if (kill || store_req) begin          // DROP
                    state_d = RSV_EMPTY;
                end else if (load_req) begin          // REARM
                    tag_d = load_tag;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // Outputs
    always_comb begin
        lock_valid = (state_q == RSV_HELD);
        rsv_tag    = tag_q;
    end

    assert_store_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !lock_valid);

    assert_kill_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !lock_valid);

    assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !kill && !store_req) |=> (lock_valid && rsv_tag == $past(load_tag)));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !store_req && !kill) |=> ($stable(lock_valid) && $stable(rsv_tag)));
endmodule

// File: rtl/llsc_monitor.sv
// Top: reservation monitor for locked-load / conditional-store.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 64,
    parameter int GRAN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              irq_event,
    input  logic              exc_event,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sc_done,
    output logic              sc_success
);
    localparam int TAG_W  = ADDR_W - GRAN_LSB;
    localparam int N_KILL = 3;

    llsc_op_e         op;
    logic             load_req, store_req;
    logic [TAG_W-1:0] req_tag, snoop_tag, rsv_tag;
    logic             lock_valid, req_hit, snoop_hit, kill;
    logic             unused_low_bits;

    assign op              = llsc_op_e'(req_op);
    assign load_req        = (op == OP_LL);
    assign store_req       = (op == OP_SC);
    assign req_tag         = req_addr[ADDR_W-1:GRAN_LSB];
    assign snoop_tag       = snoop_addr[ADDR_W-1:GRAN_LSB];
    assign unused_low_bits = ^snoop_addr[GRAN_LSB-1:0];

    llsc_tag_cmp #(.TAG_W(TAG_W)) u_req_cmp (
        .probe_tag (req_tag),
        .held_tag  (rsv_tag),
        .qual      (lock_valid),
        .hit       (req_hit)
    );

    llsc_tag_cmp #(.TAG_W(TAG_W)) u_snoop_cmp (
        .probe_tag (snoop_tag),
        .held_tag  (rsv_tag),
        .qual      (lock_valid && snoop_valid),
        .hit       (snoop_hit)
    );

    llsc_kill_merge #(.N_SRC(N_KILL)) u_kill (
        .src  ({irq_event, exc_event, snoop_hit}),
        .kill (kill)
    );

    llsc_rsv_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .store_req  (store_req),
        .kill       (kill),
        .load_tag   (req_tag),
        .lock_valid (lock_valid),
        .rsv_tag    (rsv_tag)
    );

    // Same-cycle response to a conditional store
    always_comb begin
        sc_done    = store_req;
        sc_success = store_req && req_hit && !kill;
        mem_we     = sc_success;
        mem_waddr  = sc_success ? req_addr  : '0;
        mem_wdata  = sc_success ? req_wdata : '0;
    end

    assert_success_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success |-> lock_valid);

    assert_success_granule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success |-> (req_addr[ADDR_W-1:GRAN_LSB] == rsv_tag));

    assert_snoop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |-> !mem_we);

    assert_events_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event || exc_event) |-> !mem_we);

    assert_write_only_on_sc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sc_done);
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int AW = 64;
    localparam int DW = 64;

    typedef struct {
        string       rq;
        logic        done;
        logic        ok;
        logic [63:0] addr;
        logic [63:0] data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          irq_event = 1'b0;
    logic          exc_event = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          sc_done, sc_success;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];

    // Bench-side model of the reservation
    logic        m_lock = 1'b0;
    logic [60:0] m_tag = '0;

    always #2 clk = ~clk;   // 250 MHz

    llsc_monitor u_llsc_monitor (
        .clk, .rst_n, .req_op, .req_addr, .req_wdata, .snoop_valid, .snoop_addr,
        .irq_event, .exc_event, .mem_we, .mem_waddr, .mem_wdata, .sc_done, .sc_success
    );

    task automatic fail(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    endtask

    // Driver: one request per cycle, expected response pushed to the scoreboard
    task automatic drive(string rq, logic [1:0] op, logic [63:0] a, logic [63:0] d,
                         logic sv, logic [63:0] sa, logic irq, logic exc);
        exp_t e;
        logic k;
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = d;
        snoop_valid = sv; snoop_addr = sa; irq_event = irq; exc_event = exc;
        k = irq || exc || (sv && m_lock && sa[63:3] == m_tag);
        e.rq   = rq;
        e.done = (op == 2'b10);
        e.ok   = (op == 2'b10) && m_lock && (a[63:3] == m_tag) && !k;
        e.addr = a;
        e.data = d;
        sb_q.push_back(e);
        if (k || op == 2'b10) m_lock = 1'b0;
        else if (op == 2'b01) begin m_lock = 1'b1; m_tag = a[63:3]; end
    endtask

    // Monitor: compare between edges
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (sc_done !== e.done)    fail(e.rq, "sc_done", 64'(sc_done), 64'(e.done));
            if (sc_success !== e.ok)   fail(e.rq, "sc_success", 64'(sc_success), 64'(e.ok));
            if (mem_we !== e.ok)       fail(e.rq, "mem_we", 64'(mem_we), 64'(e.ok));
            if (e.ok && mem_waddr !== e.addr) fail(e.rq, "mem_waddr", mem_waddr, e.addr);
            if (e.ok && mem_wdata !== e.data) fail(e.rq, "mem_wdata", mem_wdata, e.data);
        end
    end

    task automatic idle(string rq);
        drive(rq, 2'b00, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic ll(string rq, logic [63:0] a);
        drive(rq, 2'b01, a, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0);
    endtask

    task automatic sc(string rq, logic [63:0] a, logic [63:0] d);
        drive(rq, 2'b10, a, d, 1'b0, 64'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset
        #3;
        n_chk++;
        if (mem_we !== 1'b0 || sc_done !== 1'b0)
            fail("R1", "reset outputs", {62'b0, mem_we, sc_done}, 64'h0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        sc("R1", 64'h1000, 64'hAA);                       // no lock after reset
        // R2: success on another byte of the same granule
        ll("R2", 64'h0000_1234_5678_9A10);
        idle("R2");
        sc("R2", 64'h0000_1234_5678_9A15, 64'hDEAD_BEEF_0123_4567);
        // R5: second store fails
        sc("R5", 64'h0000_1234_5678_9A15, 64'h1);
        // R3: store with no lock
        sc("R3", 64'h2000, 64'h2);
        // R4: other granule fails, then R5: failed store also drops the lock
        ll("R4", 64'h3000);
        sc("R4", 64'h3008, 64'h3);
        sc("R5", 64'h3000, 64'h4);
        // R6: snoop hit kills, snoop miss does not
        ll("R6", 64'h4000);
        drive("R6", 2'b00, 64'h0, 64'h0, 1'b1, 64'h4007, 1'b0, 1'b0);
        sc("R6", 64'h4000, 64'h5);
        ll("R6", 64'h4000);
        drive("R6", 2'b00, 64'h0, 64'h0, 1'b1, 64'h4008, 1'b0, 1'b0);
        sc("R6", 64'h4004, 64'h6);
        // R7: interrupt
        ll("R7", 64'h5000);
        drive("R7", 2'b00, 64'h0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0);
        sc("R7", 64'h5000, 64'h7);
        // R8: exception
        ll("R8", 64'h6000);
        drive("R8", 2'b00, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1);
        sc("R8", 64'h6000, 64'h8);
        // R9: reload replaces reservation
        ll("R9", 64'h7000);
        ll("R9", 64'h7100);
        sc("R9", 64'h7000, 64'h9);
        ll("R9", 64'h7000);
        ll("R9", 64'h7100);
        sc("R9", 64'h7100, 64'h10);
        // R10: same-cycle snoop and store
        ll("R10", 64'h8000);
        drive("R10", 2'b10, 64'h8000, 64'h11, 1'b1, 64'h8003, 1'b0, 1'b0);
        // R10 control: non-hitting snoop in same cycle keeps success
        ll("R10", 64'h8000);
        drive("R10", 2'b10, 64'h8000, 64'h12, 1'b1, 64'h9000, 1'b0, 1'b0);
        // R11: kill in same cycle as load
        drive("R11", 2'b01, 64'hA000, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0);
        sc("R11", 64'hA000, 64'h13);
        drive("R11", 2'b01, 64'hA000, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1);
        sc("R11", 64'hA000, 64'h14);
        ll("R11", 64'hB000);
        drive("R11", 2'b01, 64'hB000, 64'h0, 1'b1, 64'hB000, 1'b0, 1'b0);
        sc("R11", 64'hB000, 64'h15);
        // R12: ignored codes leave the lock intact
        ll("R12", 64'hC000);
        drive("R12", 2'b11, 64'hC000, 64'h16, 1'b0, 64'h0, 1'b0, 1'b0);
        idle("R12");
        sc("R12", 64'hC000, 64'h17);

        @(negedge clk);
        req_op = 2'b00; snoop_valid = 1'b0; irq_event = 1'b0; exc_event = 1'b0;
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule